// File: doc/BRIEF.md
# Route-Partitioned Message Queue

This block buffers messages that travel between two bus-side I/O controllers. One storage array is divided into fixed regions, one per route. Each region is sized by a parameter and runs as its own circular queue between a first and a last address. A writer hands in one word and names its route. The word waits in an input staging register for one cycle and then goes into that route's region. A reader asks for a route. If that route holds data, the oldest word is loaded into an output register and shown on the next cycle.

Every route reports full and empty status, plus sticky overflow and underflow flags. Each route also has two availability notifications: space has opened for a sender, and data has arrived for a receiver. A per-route parameter sets how each route notifies. In interrupt mode the notification is a single-cycle pulse. In polled mode it is a flag that stays set until it is cleared through a clear mask.

Top module: `route_msg_fifo`

## Requirements
- R1: A word written with `wr_valid` in cycle t is stored at the second rising edge after t. A read request accepted at a rising edge shows the oldest stored word of the requested route on `rd_data`, with `rd_valid` high, for the following cycle. Words of one route come out in the order they were stored.
- R2: Routes do not interact. Storing into or reading from one route leaves the contents and status of every other route unchanged. Route r holds exactly `PART_SIZES[8r+7:8r]` words.
- R3: After reset every bit of `empty` is 1 and every bit of `full` is 0. `full[r]` is 1 exactly when route r holds its configured number of words, and `empty[r]` is 1 exactly when it holds none.
- R4: A word arriving for a full route is dropped and sets `ovf[r]`. That flag stays set until `clr_mask[r]` is 1 for one cycle.
- R5: A read request for an empty route returns no word (`rd_valid` stays 0) and sets `udf[r]`. That flag stays set until `clr_mask[r]` is 1 for one cycle.
- R6: Each route's write and read positions wrap from the route's last address back to its first. Order is kept across any number of wraps.
- R7: For a route whose `IRQ_MODE` bit is 1, `data_note[r]` is high for exactly one cycle after the route goes from empty to non-empty. `space_note[r]` is high for exactly one cycle after the route goes from full to not full.
- R8: For a route whose `IRQ_MODE` bit is 0, the same events set `data_note[r]` or `space_note[r]`. The flag stays 1 until `clr_mask[r]` is 1 for one cycle.
- R9: A stored word and a read that land on the same route at the same edge both take effect, and the route's count is unchanged. A read of an empty route is still refused in that case. Operations on two different routes at the same edge are both served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Writer presents a word this cycle |
| wr_route | input | RW | Route of the presented word |
| wr_data | input | DW | Presented word |
| rd_req | input | 1 | Reader requests a word this cycle |
| rd_route | input | RW | Route to read from |
| clr_mask | input | NR | Per-route clear of polled notes and error flags |
| rd_valid | output | 1 | `rd_data` holds a returned word |
| rd_data | output | DW | Output I/O register |
| full | output | NR | Route holds its configured size |
| empty | output | NR | Route holds no word |
| ovf | output | NR | Sticky dropped-write flag |
| udf | output | NR | Sticky refused-read flag |
| space_note | output | NR | Space-available notification |
| data_note | output | NR | Data-available notification |

## Verification
The hardest case to reach is a stored word and a read that hit the same route at the same clock edge. The input staging register delays every write by one cycle, so a write and a read presented together never meet. The bench therefore presents the write one cycle ahead of the read, so that both reach the route at the same edge. It does this once on a route that holds one word and once on an empty route, where the read must be refused. Wrapping is forced by keeping a three-word route partly full while more words go through it, so its positions cross the region boundary while data is still waiting.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int unsigned SZ_W  = 8;
  localparam int unsigned MAX_R = 32;

  function automatic int unsigned part_size(input logic [MAX_R*SZ_W-1:0] sizes,
                                            input int unsigned idx);
    return int'(sizes[idx*SZ_W +: SZ_W]);
  endfunction

  // first address of a region: sum of all sizes of lower routes
  function automatic int unsigned part_base(input logic [MAX_R*SZ_W-1:0] sizes,
                                            input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < idx; j++) acc += part_size(sizes, j);
    return acc;
  endfunction
endpackage

// File: rtl/rmf_part_ctrl.sv
module rmf_part_ctrl #(
  parameter int unsigned BASE = 0,
  parameter int unsigned SIZE = 2,
  parameter int unsigned AW   = 4,
  parameter int unsigned CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full,
  output logic          empty,
  output logic          evt_space,
  output logic          evt_data
);
  localparam logic [AW-1:0] FIRST = AW'(BASE);
  localparam logic [AW-1:0] LAST  = AW'(BASE + SIZE - 1);
  localparam logic [CW-1:0] CAP   = CW'(SIZE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic          upd_en;

  assign full    = (cnt_q == CAP);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;
  assign upd_en  = push_ok | pop_ok;
  assign evt_data  = empty & push_ok;
  assign evt_space = full & pop_ok;
  assign wptr = wp_q;
  assign rptr = rp_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == LAST) ? FIRST : wp_q + AW'(1);
    if (pop_ok)  rp_d = (rp_q == LAST) ? FIRST : rp_q + AW'(1);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wp_q  <= FIRST;
      rp_q  <= FIRST;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
    end
  end
endmodule

// File: rtl/rmf_notify.sv
module rmf_notify #(
  parameter int unsigned      NR       = 4,
  parameter logic [NR-1:0]    IRQ_MODE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] evt_space,
  input  logic [NR-1:0] evt_data,
  input  logic [NR-1:0] clr,
  output logic [NR-1:0] space_note,
  output logic [NR-1:0] data_note
);
  logic [NR-1:0] sp_q, sp_d, dt_q, dt_d;

  for (genvar i = 0; i < NR; i++) begin : g_mode
    if (IRQ_MODE[i]) begin : g_pulse
      always_comb begin
        sp_d[i] = evt_space[i];
        dt_d[i] = evt_data[i];
      end
    end else begin : g_poll
      always_comb begin
        sp_d[i] = (sp_q[i] & ~clr[i]) | evt_space[i];
        dt_d[i] = (dt_q[i] & ~clr[i]) | evt_data[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      dt_q <= '0;
    end else begin
      sp_q <= sp_d;
      dt_q <= dt_d;
    end
  end

  assign space_note = sp_q;
  assign data_note  = dt_q;
endmodule

// File: rtl/rmf_store.sv
module rmf_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 12,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // output I/O register, loaded only on an accepted read
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/route_msg_fifo.sv
module route_msg_fifo #(
  parameter int unsigned        NR         = 4,
  parameter int unsigned        DW         = 16,
  parameter logic [NR*8-1:0]    PART_SIZES = {8'd3, 8'd4, 8'd3, 8'd2},
  parameter logic [NR-1:0]      IRQ_MODE   = 4'b0101,
  parameter int unsigned        RW         = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [RW-1:0] wr_route,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic [RW-1:0] rd_route,
  input  logic [NR-1:0] clr_mask,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [NR-1:0] full,
  output logic [NR-1:0] empty,
  output logic [NR-1:0] ovf,
  output logic [NR-1:0] udf,
  output logic [NR-1:0] space_note,
  output logic [NR-1:0] data_note
);
  localparam logic [rmf_pkg::MAX_R*8-1:0] SZ_ALL = (rmf_pkg::MAX_R*8)'(PART_SIZES);
  localparam int unsigned DEPTH = rmf_pkg::part_base(SZ_ALL, NR);
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW    = rmf_pkg::SZ_W;

  // input I/O register
  logic          stg_v;
  logic [RW-1:0] stg_route;
  logic [DW-1:0] stg_data;

  logic [NR-1:0] push_req, pop_req, push_ok, pop_ok, evt_space, evt_data;
  logic [AW-1:0] wptr_a [NR];
  logic [AW-1:0] rptr_a [NR];
  logic [NR-1:0] ovf_q, ovf_d, udf_q, udf_d;
  logic          rv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v     <= 1'b0;
      stg_route <= '0;
      stg_data  <= '0;
    end else begin
      stg_v <= wr_valid;
      if (wr_valid) begin
        stg_route <= wr_route;
        stg_data  <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < NR; i++) begin : g_route
    localparam int unsigned BASE_I = rmf_pkg::part_base(SZ_ALL, i);
    localparam int unsigned SIZE_I = rmf_pkg::part_size(SZ_ALL, i);
    assign push_req[i] = stg_v  & (stg_route == RW'(i));
    assign pop_req[i]  = rd_req & (rd_route  == RW'(i));
    rmf_part_ctrl #(.BASE(BASE_I), .SIZE(SIZE_I), .AW(AW), .CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .push_req(push_req[i]), .pop_req(pop_req[i]),
      .push_ok(push_ok[i]), .pop_ok(pop_ok[i]),
      .wptr(wptr_a[i]), .rptr(rptr_a[i]),
      .full(full[i]), .empty(empty[i]),
      .evt_space(evt_space[i]), .evt_data(evt_data[i])
    );
  end

  rmf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk),
    .we(|push_ok), .waddr(wptr_a[stg_route]), .wdata(stg_data),
    .re(|pop_ok),  .raddr(rptr_a[rd_route]),  .rdata(rd_data)
  );

  rmf_notify #(.NR(NR), .IRQ_MODE(IRQ_MODE)) u_note (
    .clk(clk), .rst_n(rst_n),
    .evt_space(evt_space), .evt_data(evt_data), .clr(clr_mask),
    .space_note(space_note), .data_note(data_note)
  );

  always_comb begin
    ovf_d = (ovf_q & ~clr_mask) | (push_req & ~push_ok);
    udf_d = (udf_q & ~clr_mask) | (pop_req & ~pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      udf_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
      rv_q  <= |pop_ok;
    end
  end

  assign ovf      = ovf_q;
  assign udf      = udf_q;
  assign rd_valid = rv_q;
endmodule

// File: rtl/rmf_chk.sv
module rmf_chk #(
  parameter int unsigned   NR       = 4,
  parameter logic [NR-1:0] IRQ_MODE = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_valid,
  input logic [NR-1:0] clr_mask,
  input logic [NR-1:0] full,
  input logic [NR-1:0] empty,
  input logic [NR-1:0] ovf,
  input logic [NR-1:0] udf,
  input logic [NR-1:0] data_note
);
  assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full & empty) == '0);

  assert_rdvalid_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));

  assert_ovf_only_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf & ~$past(ovf) & ~$past(full)) == '0);

  assert_udf_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |(udf & ~$past(udf)) |-> $past(rd_req));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_note & $past(data_note) & IRQ_MODE) == '0);

  assert_poll_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(data_note) & ~data_note & ~IRQ_MODE & ~$past(clr_mask)) == '0);
endmodule

bind route_msg_fifo rmf_chk #(.NR(NR), .IRQ_MODE(IRQ_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
  .clr_mask(clr_mask), .full(full), .empty(empty), .ovf(ovf), .udf(udf),
  .data_note(data_note)
);

// File: tb/tb_route_msg_fifo.sv
module tb_route_msg_fifo;
  localparam int NR = 4;
  localparam int DW = 16;
  localparam int SZ [NR] = '{2, 3, 4, 3};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [1:0]    wr_route;
  logic [DW-1:0] wr_data;
  logic          rd_req;
  logic [1:0]    rd_route;
  logic [NR-1:0] clr_mask;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [NR-1:0] full, empty, ovf, udf, space_note, data_note;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mq [NR][$];
  logic [DW-1:0] expq [$];

  always #2 clk = ~clk;

  route_msg_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_route(wr_route),
    .wr_data(wr_data), .rd_req(rd_req), .rd_route(rd_route),
    .clr_mask(clr_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .full(full), .empty(empty), .ovf(ovf), .udf(udf),
    .space_note(space_note), .data_note(data_note)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare returned words against scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R5: actual rd_valid=1 data %0h expected no word", rd_data);
      end else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL R1: actual %0h expected %0h", rd_data, e);
        end
      end
    end
  end

  // all tasks are entered right after a falling edge
  task automatic push(input int r, input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_route = 2'(r); wr_data = d;
    if (mq[r].size() < SZ[r]) mq[r].push_back(d);
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop(input int r);
    rd_req = 1'b1; rd_route = 2'(r);
    if (mq[r].size() > 0) expq.push_back(mq[r].pop_front());
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // write staged one cycle ahead so it meets the read at the same edge (R9)
  task automatic push_meet_pop(input int rw, input logic [DW-1:0] d, input int rr);
    wr_valid = 1'b1; wr_route = 2'(rw); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_req = 1'b1; rd_route = 2'(rr);
    if (mq[rr].size() > 0) expq.push_back(mq[rr].pop_front());
    if (mq[rw].size() < SZ[rw]) mq[rw].push_back(d);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic clear(input logic [NR-1:0] m);
    clr_mask = m;
    @(negedge clk);
    clr_mask = '0;
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_route = '0; wr_data = '0;
    rd_req = 1'b0; rd_route = '0; clr_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk("R3 reset empty", 32'(empty), 32'hF);
    chk("R3 reset full", 32'(full), 32'h0);
    chk("R3 reset flags", 32'({ovf, udf, space_note, data_note}), 32'h0);
    chk("R1 reset rd_valid", 32'(rd_valid), 32'h0);

    // R7 pulse on route 0
    push(0, 16'hA000);
    chk("R7 data pulse high", 32'(data_note[0]), 32'h1);
    @(negedge clk);
    chk("R7 data pulse gone", 32'(data_note[0]), 32'h0);
    push(0, 16'hA001);
    chk("R3 route0 full", 32'(full), 32'h1);
    chk("R7 no pulse when not from empty", 32'(data_note[0]), 32'h0);
    push(0, 16'hA0FF);
    chk("R4 overflow flag", 32'(ovf), 32'h1);
    chk("R2 other routes untouched", 32'(empty), 32'hE);
    pop(0);
    chk("R7 space pulse high", 32'(space_note[0]), 32'h1);
    @(negedge clk);
    chk("R7 space pulse gone", 32'(space_note[0]), 32'h0);
    chk("R4 overflow sticky", 32'(ovf[0]), 32'h1);
    pop(0);
    pop(0);
    @(negedge clk);
    chk("R5 underflow flag", 32'(udf), 32'h1);
    chk("R4 dropped word not stored", 32'(empty[0]), 32'h1);
    clear(4'b0001);
    chk("R4 R5 flags cleared", 32'({ovf, udf}), 32'h0);

    // R8 polled route 1, R6 wrap
    push(1, 16'hB000);
    repeat (2) @(negedge clk);
    chk("R8 polled data flag holds", 32'(data_note[1]), 32'h1);
    clear(4'b0010);
    chk("R8 polled data flag cleared", 32'(data_note[1]), 32'h0);
    push(1, 16'hB001);
    push(1, 16'hB002);
    chk("R3 route1 full", 32'(full[1]), 32'h1);
    pop(1);
    pop(1);
    repeat (2) @(negedge clk);
    chk("R8 polled space flag holds", 32'(space_note[1]), 32'h1);
    push(1, 16'hB003);
    push(1, 16'hB004);
    pop(1);
    push(1, 16'hB005);
    pop(1); pop(1); pop(1);
    @(negedge clk);
    chk("R6 route1 drained after wrap", 32'(empty[1]), 32'h1);
    clear(4'b0010);
    chk("R8 polled space flag cleared", 32'(space_note[1]), 32'h0);

    // R2 independence, interleaved routes
    push(2, 16'hC000);
    push(3, 16'hD000);
    push(2, 16'hC001);
    push(3, 16'hD001);
    push(2, 16'hC002);
    chk("R2 route2/3 occupied", 32'(empty), 32'h3);
    pop(3); pop(2); pop(3); pop(2);
    chk("R2 route2 keeps one", 32'(empty[2]), 32'h0);
    pop(2);
    @(negedge clk);
    chk("R2 all empty", 32'(empty), 32'hF);

    // R9 same-route meet with one word held
    push(3, 16'hE000);
    push_meet_pop(3, 16'hE001, 3);
    @(negedge clk);
    chk("R9 count kept", 32'({full[3], empty[3]}), 32'h0);
    pop(3);
    @(negedge clk);
    chk("R9 route3 empty after pop", 32'(empty[3]), 32'h1);
    // R9 same-route meet on empty route: read refused, write kept
    push_meet_pop(2, 16'hE100, 2);
    @(negedge clk);
    chk("R9 refused read on empty", 32'(udf[2]), 32'h1);
    chk("R9 write kept", 32'(empty[2]), 32'h0);
    // R9 different routes at the same edge
    push(3, 16'hE200);
    push_meet_pop(0, 16'hE300, 3);
    @(negedge clk);
    chk("R9 both routes served", 32'({empty[3], empty[0]}), 32'h2);
    pop(2); pop(0);
    repeat (2) @(negedge clk);
    chk("R1 scoreboard drained", 32'(expq.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule